// File: doc/BRIEF.md
# Kernel Stack Limit Zone Checker

This block guards the kernel stack against running below a programmable floor. Every time the processor decrements SP in kernel mode, it compares the new SP with the limit. This covers an explicit push and an autodecrement through SP. If SP has only just crossed the floor, the block raises a sticky yellow request. The trap sequencer takes that request once the current instruction has retired. If SP has fallen more than 32 bytes under the floor, the block instead fires a one-cycle red abort and asks for SP to be forced to 4, so that the abort frame has somewhere to land.

The limit is a bus-visible register. Only its high byte is kept, and a stored zero acts as a floor of 0o400. Writing the limit makes the block test the current SP against the new floor on the following cycle. The block also holds the CPU error register. Red and yellow events set their bits there, and other fault sources OR their bits in through `err_set`. The bits stay set until software writes the register. The writes of the saved PC and PSW during trap entry are exempt from checking. A pending yellow request drops when the sequencer reports that the trap frame has been stored, so servicing yellow never re-raises it.

The register port takes a write on any cycle with no back-pressure. Read data is a combinational function of `bus_addr`.

Top module: `stack_limit_checker`

## Requirements
- R1: With `kernel_mode` low, no push and no limit write ever produces `red_abort`, `yellow_req` or a red/yellow error bit.
- R2: A bus write at offset 0o17774 stores bits 15:8 of the data and clears bits 7:0; a read at that offset returns the stored value.
- R3: A stored limit of zero behaves as a floor of 0o400.
- R4: A checked kernel push with SP below the floor, but not more than 32 below, sets `yellow_req` on the next cycle and error bit 3 (0o010); `yellow_req` stays high until cleared.
- R5: A checked kernel push with SP+32 below the floor pulses `red_abort` and `sp_force_en` for exactly one cycle, starting on the next cycle, with `sp_force_val` equal to 4, and sets error bit 2 (0o004).
- R6: When the red condition holds, it takes precedence, and the same event leaves `yellow_req` and error bit 3 unchanged.
- R7: A push with `frame_push` high is never checked.
- R8: A `frame_done` pulse clears `yellow_req` on the next cycle.
- R9: A limit write checks `sp_now` against the new floor one cycle after the write, with the same rules as a push; reset by itself triggers no check.
- R10: The error register at offset 0o17766 (read as the low byte) keeps bits 7:2 only. Bits requested through `err_set` or by red/yellow events accumulate. A bus write replaces the stored bits with the written bits 7:2, and set requests in that same cycle are OR-ed on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_mode | input | 1 | High while the current mode is kernel |
| push_stb | input | 1 | SP was decremented this cycle |
| frame_push | input | 1 | The decrement belongs to a trap-frame store (exempt) |
| sp_new | input | 16 | SP value after the decrement |
| sp_now | input | 16 | Current SP, used for the check after a limit write |
| frame_done | input | 1 | Trap frame stored; clears the yellow request |
| bus_addr | input | 13 | I/O page offset of the register access |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| err_set | input | 8 | Error bits raised by other fault sources |
| yellow_req | output | 1 | Deferred yellow-zone trap request |
| red_abort | output | 1 | One-cycle red-zone abort |
| sp_force_en | output | 1 | Load `sp_force_val` into SP |
| sp_force_val | output | 16 | Forced SP value (4) |
| err_reg | output | 8 | CPU error register contents |

## Verification
The properties assume three things about the inputs. `frame_done` is never asserted in a cycle that also brings a checked push or a post-write check. Pushes marked `frame_push` are not paired with a limit-write check. `kernel_mode` is stable across the cycle of an event. The bench meets all three by driving each stimulus alone on its own cycle, always separating a limit write from the next push by an idle cycle and clearing the yellow request in a quiet cycle. It then sweeps all 256 limit bytes with SP placed on each side of both the yellow and red boundaries.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int DATA_W      = 16;
  localparam int ERR_W       = 8;
  localparam int LIM_KEEP_LO = 8;
  localparam int RED_MARGIN  = 32;
  localparam logic [DATA_W-1:0] LIMIT_FLOOR = 16'o000400;
  localparam logic [DATA_W-1:0] FORCED_SP   = 16'o000004;
  localparam int ERR_RED_BIT = 2;
  localparam int ERR_YEL_BIT = 3;
  localparam logic [ERR_W-1:0] ERR_KEEP = 8'o374;
endpackage

// File: rtl/slc_limit_reg.sv
module slc_limit_reg
  import slc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lim_q,
  output logic [DATA_W-1:0] eff_lim,
  output logic              chk_pend
);
  localparam int HI_W = DATA_W - LIM_KEEP_LO;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      chk_pend <= 1'b0;
    end else begin
      chk_pend <= wr_en;
      if (wr_en) hi_q <= wdata[DATA_W-1:LIM_KEEP_LO];
    end
  end

  assign lim_q   = {hi_q, {LIM_KEEP_LO{1'b0}}};
  assign eff_lim = (hi_q == '0) ? LIMIT_FLOOR : lim_q;
endmodule

// File: rtl/slc_zone_cmp.sv
module slc_zone_cmp
  import slc_pkg::*;
(
  input  logic [DATA_W-1:0] sp,
  input  logic [DATA_W-1:0] eff_lim,
  output logic              yellow_o,
  output logic              red_o
);
  logic [DATA_W:0] sp_ext, lim_ext;

  always_comb begin
    sp_ext   = {1'b0, sp};
    lim_ext  = {1'b0, eff_lim};
    yellow_o = sp_ext < lim_ext;
    red_o    = (sp_ext + (DATA_W+1)'(RED_MARGIN)) < lim_ext;
  end

  // the red band lies wholly inside the yellow band (R6)
  always_comb begin
    if (red_o === 1'b1)
      assert_red_inside_yellow_R6: assert (yellow_o === 1'b1);
  end
endmodule

// File: rtl/slc_err_reg.sv
module slc_err_reg
  import slc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ERR_W-1:0] wdata,
  input  logic [ERR_W-1:0] set_bits,
  output logic [ERR_W-1:0] q
);
  logic [ERR_W-1:0] base;

  always_comb base = wr_en ? (wdata & ERR_KEEP) : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= base | (set_bits & ERR_KEEP);
  end

  assert_bits_stick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/stack_limit_checker.sv
module stack_limit_checker
  import slc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] LIM_OFFS = 13'o17774,
  parameter logic [ADDR_W-1:0] ERR_OFFS = 13'o17766
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kernel_mode,
  input  logic              push_stb,
  input  logic              frame_push,
  input  logic [DATA_W-1:0] sp_new,
  input  logic [DATA_W-1:0] sp_now,
  input  logic              frame_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ERR_W-1:0]  err_set,
  output logic              yellow_req,
  output logic              red_abort,
  output logic              sp_force_en,
  output logic [DATA_W-1:0] sp_force_val,
  output logic [ERR_W-1:0]  err_reg
);
  logic              lim_wr, err_wr;
  logic [DATA_W-1:0] lim_q, eff_lim;
  logic              chk_pend;
  logic              p_yel, p_red, w_yel, w_red;
  logic              push_ok, red_hit, yel_hit;
  logic [ERR_W-1:0]  set_bits;
  logic              red_q;

  assign lim_wr = bus_wr && (bus_addr == LIM_OFFS);
  assign err_wr = bus_wr && (bus_addr == ERR_OFFS);

  slc_limit_reg u_lim (
    .clk(clk), .rst_n(rst_n), .wr_en(lim_wr), .wdata(bus_wdata),
    .lim_q(lim_q), .eff_lim(eff_lim), .chk_pend(chk_pend)
  );

  slc_zone_cmp u_cmp_push (
    .sp(sp_new), .eff_lim(eff_lim), .yellow_o(p_yel), .red_o(p_red)
  );

  slc_zone_cmp u_cmp_wr (
    .sp(sp_now), .eff_lim(eff_lim), .yellow_o(w_yel), .red_o(w_red)
  );

  always_comb begin
    push_ok = push_stb && !frame_push;
    red_hit = kernel_mode && ((push_ok && p_red) || (chk_pend && w_red));
    yel_hit = kernel_mode && ((push_ok && p_yel) || (chk_pend && w_yel)) && !red_hit;
    set_bits = err_set;
    set_bits[ERR_RED_BIT] = set_bits[ERR_RED_BIT] | red_hit;
    set_bits[ERR_YEL_BIT] = set_bits[ERR_YEL_BIT] | yel_hit;
  end

  slc_err_reg u_err (
    .clk(clk), .rst_n(rst_n), .wr_en(err_wr), .wdata(bus_wdata[ERR_W-1:0]),
    .set_bits(set_bits), .q(err_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yellow_req <= 1'b0;
      red_q      <= 1'b0;
    end else begin
      red_q <= red_hit;
      if (yel_hit)         yellow_req <= 1'b1;
      else if (frame_done) yellow_req <= 1'b0;
    end
  end

  assign red_abort    = red_q;
  assign sp_force_en  = red_q;
  assign sp_force_val = FORCED_SP;

  always_comb begin
    if (bus_addr == LIM_OFFS)      bus_rdata = lim_q;
    else if (bus_addr == ERR_OFFS) bus_rdata = {{(DATA_W-ERR_W){1'b0}}, err_reg};
    else                           bus_rdata = '0;
  end

  assert_user_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel_mode |=> !red_abort);

  assert_red_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |-> err_reg[ERR_RED_BIT]);

  assert_yellow_logged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yellow_req) |-> err_reg[ERR_YEL_BIT]);

  assert_frame_exempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_stb && frame_push && !chk_pend) |=> !red_abort);

  assert_yellow_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !(push_stb && !frame_push) && !chk_pend) |=> !yellow_req);
endmodule

// File: tb/stack_limit_checker_test.sv
module stack_limit_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel_mode = 1'b1;
  logic        push_stb = 1'b0, frame_push = 1'b0, frame_done = 1'b0;
  logic [15:0] sp_new = '0, sp_now = 16'hFFFF;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  err_set = '0;
  logic        yellow_req, red_abort, sp_force_en;
  logic [15:0] sp_force_val;
  logic [7:0]  err_reg;

  localparam logic [12:0] LIM_A = 13'o17774;
  localparam logic [12:0] ERR_A = 13'o17766;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  stack_limit_checker uut (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .push_stb(push_stb),
    .frame_push(frame_push), .sp_new(sp_new), .sp_now(sp_now),
    .frame_done(frame_done), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_set(err_set),
    .yellow_req(yellow_req), .red_abort(red_abort), .sp_force_en(sp_force_en),
    .sp_force_val(sp_force_val), .err_reg(err_reg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clear_state();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    wr(ERR_A, 16'h0000);
  endtask

  task automatic push(input logic [15:0] sp, input logic fp);
    sp_new = sp; frame_push = fp; push_stb = 1'b1;
    @(negedge clk);
    push_stb = 1'b0; frame_push = 1'b0;
  endtask

  function automatic int floor_of(input int b);
    return (b == 0) ? 256 : b * 256;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    sp_now = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    // reset state; reset with SP 0 starts no check (R9)
    chk("R9 reset no check", {red_abort, yellow_req, sp_force_en}, 0);
    chk("R10 reset err", err_reg, 0);
    bus_addr = LIM_A; #1;
    chk("R2 reset limit", bus_rdata, 0);
    sp_now = 16'hFFFF;

    // R2 masking and readback
    wr(LIM_A, 16'o123456);
    idle();
    bus_addr = LIM_A; #1;
    chk("R2 limit mask", bus_rdata, 16'o123400);

    // sweep of every limit byte, R3 R4 R5 R6
    for (int b = 0; b < 256; b++) begin
      int fl;
      int pts[6];
      fl = floor_of(b);
      wr(LIM_A, 16'(b << 8));
      idle();
      clear_state();
      pts[0] = fl - 33; pts[1] = fl - 32; pts[2] = fl - 1;
      pts[3] = fl;      pts[4] = fl + 1;  pts[5] = 0;
      for (int k = 0; k < 6; k++) begin
        int sp;
        logic er, ey;
        sp = pts[k];
        if (sp < 0 || sp > 65535) continue;
        er = (sp + 32) < fl;
        ey = !er && (sp < fl);
        push(16'(sp), 1'b0);
        chk(b == 0 ? "R3 red zero floor" : "R5 red abort", red_abort, er);
        chk("R5 force enable", sp_force_en, er);
        if (er) chk("R5 forced sp", sp_force_val, 16'd4);
        chk(er ? "R6 red precedence" : "R4 yellow req", yellow_req, ey);
        chk("R10 err bits", err_reg, {4'b0, ey, er, 2'b0});
        idle();
        chk("R5 one cycle pulse", red_abort, 0);
        chk("R4 yellow held", yellow_req, ey);
        clear_state();
      end
    end

    // R1 user mode: deep red SP never trips
    wr(LIM_A, 16'o100000);
    idle(); clear_state();
    kernel_mode = 1'b0;
    push(16'd0, 1'b0);
    chk("R1 user red", red_abort, 0);
    chk("R1 user yellow", yellow_req, 0);
    sp_now = 16'd0;
    wr(LIM_A, 16'o100000);
    idle();
    chk("R1 user limit write", {red_abort, yellow_req, err_reg}, 0);
    sp_now = 16'hFFFF;
    kernel_mode = 1'b1;

    // R7 trap-frame pushes exempt
    push(16'd0, 1'b1);
    chk("R7 frame push red", red_abort, 0);
    chk("R7 frame push yellow", yellow_req, 0);
    chk("R7 frame push err", err_reg, 0);

    // R8 yellow cleared by frame_done
    push(16'o077770, 1'b0);
    chk("R8 yellow set", yellow_req, 1);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R8 yellow cleared", yellow_req, 0);
    clear_state();

    // R9 limit write checks sp_now a cycle later
    sp_now = 16'o000100;
    wr(LIM_A, 16'o001000);
    chk("R9 not yet", red_abort, 0);
    idle();
    chk("R9 red after write", red_abort, 1);
    chk("R9 red force", sp_force_en, 1);
    clear_state();
    sp_now = 16'o000770;
    wr(LIM_A, 16'o001000);
    idle();
    chk("R9 yellow after write", {red_abort, yellow_req}, 2'b01);
    sp_now = 16'hFFFF;
    clear_state();

    // R10 accumulate, external bits, masked write
    err_set = 8'o160;
    @(negedge clk);
    err_set = 8'o001;
    @(negedge clk);
    err_set = 8'o000;
    chk("R10 external accumulate", err_reg, 8'o160);
    push(16'd0, 1'b0);
    chk("R10 red accumulates", err_reg, 8'o164);
    wr(ERR_A, 16'o000377);
    bus_addr = ERR_A; #1;
    chk("R10 masked write", bus_rdata, 16'o000374);
    wr(ERR_A, 16'o000010);
    chk("R10 write replaces", err_reg, 8'o010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule